// File: doc/BRIEF.md
# In-Place Block Transform Engine with Byte-Wide Command Window

The engine is set up through a narrow command port. Each command carries a 2-bit operation, a 16-bit address and an 8-bit data byte. Registered read data comes back on an 8-bit output. Inside a 64-byte window of the command address space the block exposes these registers:

- a buffer base address
- a length
- a key-select bit
- a 128-bit counter
- two 128-bit keys

The block has no bus wider than a byte, so each multi-byte register is loaded and read back one byte at a time, least significant byte first.

A start command launches the in-place pass over the buffer. The engine fetches a 16-byte block one byte per cycle and mixes it in one cycle. It then stores the block back to the same addresses, again one byte per cycle. It repeats this until the length is covered and then returns to idle. The mixing step XORs the block with the selected key and with the counter. It stands in for a real cipher round and can be swapped out behind the same interface.

The controller has four named states:

- **IDLE** (0): waits for a start.
- **LOAD** (1): reads one block byte per cycle.
- **MIX** (2): transforms the whole block in one cycle.
- **STORE** (3): writes one block byte per cycle.

The transitions are:

- **go**: IDLE to LOAD, on a start command.
- **filled**: LOAD to MIX, after the 16th byte.
- **mixed**: MIX to STORE, always.
- **next**: STORE to LOAD, when more data remains.
- **finish**: STORE to IDLE, when the length is covered.

Top module: `blkxf_dma`

## Requirements
- R1: After reset the engine is IDLE, `mem_we` is 0, `cmd_rdata` is 0x00, and every register reads back as 0.
- R2: A `cmd` value of 1 is a read and 2 is a write. The values 0 and 3 are no-ops and change no register, even when they carry the window address and data.
- R3: The registers sit at the following offsets from 0xFF00. Multi-byte fields are little-endian, so the lowest offset holds bits 7:0.
  - 0x00: start (write-only, reads 0x00)
  - 0x01: state (read-only)
  - 0x02–0x03: base address
  - 0x04–0x05: length
  - 0x06: key select (bit 0)
  - 0x10–0x1F: counter
  - 0x20–0x2F: key 0
  - 0x30–0x3F: key 1
- R4: Read data appears on `cmd_rdata` at the clock edge that accepts the read command, so it is visible one cycle after the command is driven. A read of an unmapped offset, or of any address outside 0xFF00–0xFF3F, returns 0x00.
- R5: Register writes take effect only while the state is IDLE; writes in any other state are dropped. Reads are served in every state, and offset 0x01 returns the current state code.
- R6: Writing data 0x01 to offset 0x00 while IDLE moves the state to LOAD at that edge. Any other data value at that offset leaves the engine IDLE.
- R7: Every block takes 16 LOAD cycles, then exactly one MIX cycle, then 16 STORE cycles. The only state changes are those named above.
- R8: Byte k (0 to 15) of block b is read from, and written back to, memory address base + 16·b + k. Byte k of the block occupies bits 8k+7:8k of the 128-bit value.
- R9: The stored block is the loaded block XOR the counter XOR a key: key 0 when key select is 0, key 1 when it is 1.
- R10: After each block the engine adds 16 to the block offset. If the result is below the length, it runs another block; otherwise it returns to IDLE. A pass therefore covers max(1, ⌈length/16⌉) blocks, and a zero length still processes one block.
- R11: Memory addresses wrap modulo 2^16, so a buffer that crosses 0xFFFF continues at 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 2 | Command operation: 1 read, 2 write, otherwise no-op |
| cmd_addr | input | 16 | Command address |
| cmd_wdata | input | 8 | Command write byte |
| cmd_rdata | output | 8 | Registered read byte |
| mem_addr | output | 16 | Byte address to the buffer memory |
| mem_wdata | output | 8 | Byte written to memory during STORE |
| mem_we | output | 1 | Memory write strobe, high in STORE |
| mem_rdata | input | 8 | Byte read from memory, valid in the same cycle as `mem_addr` |

## Verification
The hardest situation to reach from the ports is the end-of-pass decision. It depends on how the block offset compares with the length, so whether the last block finishes early or runs on shows up only at a few length values.

The bench sweeps every length from 0 to 64 at shifting base addresses, alternating the key select. While each pass runs, it holds a read of the state register every cycle. From those samples it counts the LOAD, MIX and STORE cycles and compares the counts with the block count it predicts from the length. It then compares the whole memory image with its own XOR model.

Two more passes are started just below 0xFFFF to reach the address wrap. One pass is hit with register writes and a second start while busy, which checks that the busy lock holds in the middle of a run.

// File: rtl/blkxf_pkg.sv
package blkxf_pkg;
    localparam int BLK_BYTES = 16;
    localparam int BLK_BITS  = BLK_BYTES * 8;
    localparam int IDX_W     = $clog2(BLK_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_MIX   = 2'd2,
        ST_STORE = 2'd3
    } xf_state_e;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_RD   = 2'd1,
        CMD_WR   = 2'd2,
        CMD_NOP3 = 2'd3
    } cmd_op_e;
endpackage

// File: rtl/blkxf_regs.sv
module blkxf_regs
    import blkxf_pkg::*;
#(
    parameter int          AW       = 16,
    parameter logic [15:0] WIN_BASE = 16'hFF00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cmd,
    input  logic [AW-1:0]       cmd_addr,
    input  logic [7:0]          cmd_wdata,
    input  logic [1:0]          state,
    output logic [7:0]          cmd_rdata,
    output logic                start,
    output logic [AW-1:0]       base,
    output logic [AW-1:0]       len,
    output logic                ksel,
    output logic [BLK_BITS-1:0] ctr,
    output logic [BLK_BITS-1:0] key0,
    output logic [BLK_BITS-1:0] key1
);
    localparam int WIN_LSB = 6;

    logic       in_win;
    logic [5:0] off;
    logic       wr_ok;
    logic [7:0] rsel;

    assign in_win = (cmd_addr[AW-1:WIN_LSB] == WIN_BASE[AW-1:WIN_LSB]);
    assign off    = cmd_addr[WIN_LSB-1:0];
    assign wr_ok  = (cmd == CMD_WR) && in_win && (state == ST_IDLE);
    assign start  = wr_ok && (off == 6'd0) && (cmd_wdata == 8'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base <= '0;
            len  <= '0;
            ksel <= 1'b0;
            ctr  <= '0;
            key0 <= '0;
            key1 <= '0;
        end else if (wr_ok) begin
            unique case (off[5:4])
                2'd0: begin
                    case (off[3:0])
                        4'd2, 4'd3: base[{off[0], 3'b000} +: 8] <= cmd_wdata;
                        4'd4, 4'd5: len[{off[0], 3'b000} +: 8]  <= cmd_wdata;
                        4'd6:       ksel <= cmd_wdata[0];
                        default:    ;
                    endcase
                end
                2'd1: ctr[{off[3:0], 3'b000} +: 8]  <= cmd_wdata;
                2'd2: key0[{off[3:0], 3'b000} +: 8] <= cmd_wdata;
                2'd3: key1[{off[3:0], 3'b000} +: 8] <= cmd_wdata;
            endcase
        end
    end

    always_comb begin
        rsel = 8'h00;
        if (in_win) begin
            unique case (off[5:4])
                2'd0: begin
                    case (off[3:0])
                        4'd1:       rsel = {6'd0, state};
                        4'd2, 4'd3: rsel = base[{off[0], 3'b000} +: 8];
                        4'd4, 4'd5: rsel = len[{off[0], 3'b000} +: 8];
                        4'd6:       rsel = {7'd0, ksel};
                        default:    rsel = 8'h00;
                    endcase
                end
                2'd1: rsel = ctr[{off[3:0], 3'b000} +: 8];
                2'd2: rsel = key0[{off[3:0], 3'b000} +: 8];
                2'd3: rsel = key1[{off[3:0], 3'b000} +: 8];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cmd_rdata <= 8'h00;
        else if (cmd == CMD_RD)
            cmd_rdata <= rsel;
    end
endmodule

// File: rtl/blkxf_mix.sv
module blkxf_mix
    import blkxf_pkg::*;
(
    input  logic [BLK_BITS-1:0] blk_in,
    input  logic [BLK_BITS-1:0] ctr,
    input  logic [BLK_BITS-1:0] key0,
    input  logic [BLK_BITS-1:0] key1,
    input  logic                ksel,
    output logic [BLK_BITS-1:0] blk_out
);
    logic [BLK_BITS-1:0] key_use;

    assign key_use = ksel ? key1 : key0;
    assign blk_out = blk_in ^ key_use ^ ctr;
endmodule

// File: rtl/blkxf_engine.sv
module blkxf_engine
    import blkxf_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [AW-1:0]       base,
    input  logic [AW-1:0]       len,
    input  logic [BLK_BITS-1:0] blk_mixed,
    input  logic [7:0]          mem_rdata,
    output xf_state_e           state,
    output logic [BLK_BITS-1:0] blk_q,
    output logic [AW-1:0]       mem_addr,
    output logic [7:0]          mem_wdata,
    output logic                mem_we
);
    xf_state_e        st_d;
    logic [IDX_W-1:0] idx_q;
    logic [AW-1:0]    off_q;
    logic [AW:0]      off_nx;
    logic             last_byte;
    logic             more;

    assign last_byte = (idx_q == IDX_W'(BLK_BYTES - 1));
    assign off_nx    = {1'b0, off_q} + (AW+1)'(BLK_BYTES);
    assign more      = (off_nx < {1'b0, len});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= st_d;
    end

    always_comb begin
        st_d = state;
        unique case (state)
            ST_IDLE:  if (start) st_d = ST_LOAD;
            ST_LOAD:  if (last_byte) st_d = ST_MIX;
            ST_MIX:   st_d = ST_STORE;
            ST_STORE: if (last_byte) st_d = more ? ST_LOAD : ST_IDLE;
        endcase
    end

    always_comb begin
        mem_addr  = base + off_q + AW'(idx_q);
        mem_we    = (state == ST_STORE);
        mem_wdata = blk_q[{idx_q, 3'b000} +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            off_q <= '0;
            blk_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        idx_q <= '0;
                        off_q <= '0;
                    end
                end
                ST_LOAD: begin
                    blk_q[{idx_q, 3'b000} +: 8] <= mem_rdata;
                    idx_q <= idx_q + 1'b1;
                end
                ST_MIX: blk_q <= blk_mixed;
                ST_STORE: begin
                    idx_q <= idx_q + 1'b1;
                    if (last_byte && more) off_q <= off_nx[AW-1:0];
                end
            endcase
        end
    end
endmodule

// File: rtl/blkxf_dma.sv
module blkxf_dma
    import blkxf_pkg::*;
#(
    parameter int          AW       = 16,
    parameter logic [15:0] WIN_BASE = 16'hFF00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cmd,
    input  logic [AW-1:0] cmd_addr,
    input  logic [7:0]    cmd_wdata,
    output logic [7:0]    cmd_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          mem_we,
    input  logic [7:0]    mem_rdata
);
    xf_state_e           eng_state;
    logic                start_pulse;
    logic                key_sel;
    logic [AW-1:0]       base;
    logic [AW-1:0]       len;
    logic [BLK_BITS-1:0] ctr;
    logic [BLK_BITS-1:0] key0;
    logic [BLK_BITS-1:0] key1;
    logic [BLK_BITS-1:0] blk_q;
    logic [BLK_BITS-1:0] blk_mixed;

    blkxf_regs #(.AW(AW), .WIN_BASE(WIN_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .state(eng_state), .cmd_rdata(cmd_rdata),
        .start(start_pulse), .base(base), .len(len), .ksel(key_sel),
        .ctr(ctr), .key0(key0), .key1(key1)
    );

    blkxf_mix u_mix (
        .blk_in(blk_q), .ctr(ctr), .key0(key0), .key1(key1),
        .ksel(key_sel), .blk_out(blk_mixed)
    );

    blkxf_engine #(.AW(AW)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start_pulse), .base(base),
        .len(len), .blk_mixed(blk_mixed), .mem_rdata(mem_rdata),
        .state(eng_state), .blk_q(blk_q), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we)
    );
endmodule

// File: rtl/blkxf_dma_chk.sv
module blkxf_dma_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  cmd,
    input logic [15:0] cmd_addr,
    input logic [1:0]  state,
    input logic        start,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic [7:0]  cmd_rdata,
    input logic        ksel
);
    p_mix_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd2) |=> (state == 2'd3));

    p_store_follows_mix_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> ($past(state) == 2'd2));

    p_load_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == 2'd1) && ($past(state) == 2'd1)) |-> (mem_addr == $past(mem_addr) + 16'd1));

    p_state_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == 2'd1) && (cmd_addr == 16'hFF01)) |=> (cmd_rdata == {6'd0, $past(state)}));

    p_busy_write_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != 2'd0) && (cmd == 2'd2) && (cmd_addr == 16'hFF06)) |=> $stable(ksel));

    p_start_enters_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == 2'd0) && start) |=> (state == 2'd1));
endmodule

bind blkxf_dma blkxf_dma_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_addr(cmd_addr),
    .state(eng_state), .start(start_pulse), .mem_we(mem_we),
    .mem_addr(mem_addr), .cmd_rdata(cmd_rdata), .ksel(key_sel)
);

// File: tb/sim_blkxf_dma.sv
module sim_blkxf_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd = 2'd0;
    logic [15:0] cmd_addr = 16'd0;
    logic [7:0]  cmd_wdata = 8'd0;
    logic [7:0]  cmd_rdata;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata;

    logic [7:0]  mem [0:1023];
    logic [7:0]  expm [0:1023];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    blkxf_dma u0 (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr[9:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= 8'(i * 7 + 3);
        end else if (mem_we) begin
            mem[mem_addr[9:0]] <= mem_wdata;
        end
    end

    function automatic logic [7:0] ctr_b(input int i);  return 8'(8'hA0 ^ (i * 5));  endfunction
    function automatic logic [7:0] key0_b(input int i); return 8'(8'h3C + i * 9);    endfunction
    function automatic logic [7:0] key1_b(input int i); return 8'(8'hC5 ^ (i * 17)); endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic drive(input logic [1:0] c, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd = c; cmd_addr = a; cmd_wdata = d;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        drive(2'd2, a, d);
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        drive(2'd1, a, 8'd0);
        @(negedge clk);
        d = cmd_rdata;
        cmd = 2'd0;
    endtask

    task automatic compare_mem(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < 1024; i++)
            if (mem[i] !== expm[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        check(bad == 0, req, bad, 0);
        if (bad != 0) $display("  first mismatch at %0h", first);
    endtask

    function automatic int nblocks(input logic [15:0] len);
        return (len == 16'd0) ? 1 : (int'(len) + 15) / 16;
    endfunction

    task automatic model_op(input logic [15:0] base, input logic [15:0] len, input bit ks);
        for (int b = 0; b < nblocks(len); b++)
            for (int k = 0; k < 16; k++) begin
                logic [15:0] a;
                a = base + 16'(16 * b + k);
                expm[a[9:0]] = expm[a[9:0]] ^ ctr_b(k) ^ (ks ? key1_b(k) : key0_b(k));
            end
    endtask

    task automatic setup(input logic [15:0] base, input logic [15:0] len, input bit ks);
        wr(16'hFF02, base[7:0]);
        wr(16'hFF03, base[15:8]);
        wr(16'hFF04, len[7:0]);
        wr(16'hFF05, len[15:8]);
        wr(16'hFF06, {7'd0, ks});
    endtask

    task automatic run_op(input logic [15:0] base, input logic [15:0] len, input bit ks,
                          input string req);
        int n_ld = 0, n_mx = 0, n_st = 0, guard = 0;
        bit order_ok = 1;
        logic [1:0] prev = 2'd1;
        logic [1:0] v;
        int nb;
        nb = nblocks(len);
        setup(base, len, ks);
        model_op(base, len, ks);
        wr(16'hFF00, 8'd1);
        drive(2'd1, 16'hFF01, 8'd0);
        @(negedge clk);
        v = cmd_rdata[1:0];
        check(v == 2'd1, "R6 first busy state is LOAD", v, 1);
        while (v != 2'd0 && guard < 5000) begin
            case (v)
                2'd1: n_ld++;
                2'd2: n_mx++;
                default: n_st++;
            endcase
            @(negedge clk);
            v = cmd_rdata[1:0];
            if (v != 2'd0 && !((prev == v) || (prev == 2'd1 && v == 2'd2) ||
                (prev == 2'd2 && v == 2'd3) || (prev == 2'd3 && v == 2'd1)))
                order_ok = 0;
            if (prev == 2'd2 && v != 2'd3) order_ok = 0;
            if (v != 2'd0) prev = v;
            guard++;
        end
        cmd = 2'd0;
        check(order_ok && prev == 2'd3, "R7 state order", prev, 3);
        check(n_ld == 16 * nb && n_mx == nb && n_st == 16 * nb,
              "R7/R10 cycles per state", n_ld + n_mx + n_st, 33 * nb);
        compare_mem(req);
    endtask

    function automatic logic [7:0] reg_exp(input int off);
        if (off == 2) return 8'h34;
        if (off == 3) return 8'h12;
        if (off == 4) return 8'hEF;
        if (off == 5) return 8'hBE;
        if (off == 6) return 8'h01;
        if (off >= 16 && off < 32) return ctr_b(off - 16);
        if (off >= 32 && off < 48) return key0_b(off - 32);
        if (off >= 48) return key1_b(off - 48);
        return 8'h00;
    endfunction

    initial begin
        repeat (600000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < 1024; i++) expm[i] = 8'(i * 7 + 3);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cmd_rdata == 8'h00, "R1 read data after reset", cmd_rdata, 0);
        check(mem_we == 1'b0, "R1 no write after reset", mem_we, 0);
        rst_n = 1'b1;
        rd(16'hFF01, d); check(d == 8'h00, "R1 state idle", d, 0);
        rd(16'hFF04, d); check(d == 8'h00, "R1 length cleared", d, 0);
        rd(16'hFF20, d); check(d == 8'h00, "R1 key0 cleared", d, 0);

        // R3 full window readback
        setup(16'h1234, 16'hBEEF, 1'b1);
        for (int i = 0; i < 16; i++) begin
            wr(16'hFF10 + 16'(i), ctr_b(i));
            wr(16'hFF20 + 16'(i), key0_b(i));
            wr(16'hFF30 + 16'(i), key1_b(i));
        end
        for (int off = 0; off < 64; off++) begin
            rd(16'hFF00 + 16'(off), d);
            check(d == reg_exp(off), $sformatf("R3 offset %0h", off), d, reg_exp(off));
        end
        rd(16'h1234, d); check(d == 8'h00, "R4 outside window", d, 0);
        rd(16'hFF40, d); check(d == 8'h00, "R4 above window", d, 0);
        // R4 one-cycle latency on back-to-back reads
        drive(2'd1, 16'hFF02, 8'd0);
        drive(2'd1, 16'hFF03, 8'd0);
        check(cmd_rdata == 8'h34, "R4 first read latency", cmd_rdata, 8'h34);
        @(negedge clk);
        check(cmd_rdata == 8'h12, "R4 second read latency", cmd_rdata, 8'h12);
        cmd = 2'd0;

        // R2 no-op codes
        wr(16'hFF06, 8'd0);
        drive(2'd3, 16'hFF06, 8'd1);
        drive(2'd0, 16'hFF06, 8'd1);
        rd(16'hFF06, d); check(d == 8'h00, "R2 codes 0 and 3 ignored", d, 0);
        drive(2'd3, 16'hFF00, 8'd1);
        rd(16'hFF01, d); check(d == 8'h00, "R2 no-op start ignored", d, 0);

        // R6 start with wrong value
        setup(16'h0100, 16'd16, 1'b0);
        wr(16'hFF00, 8'd2);
        rd(16'hFF01, d); check(d == 8'h00, "R6 start value 2 ignored", d, 0);
        compare_mem("R6 memory untouched");

        // R8 R9 R10 length sweep
        for (int l = 0; l <= 64; l++)
            run_op(16'h0010 + 16'(l * 11), 16'(l), l[0], $sformatf("R8/R9/R10 len %0d", l));

        // R11 wrap
        run_op(16'hFFF8, 16'd16, 1'b0, "R11 wrap one block");
        run_op(16'hFFF0, 16'd40, 1'b1, "R11 wrap three blocks");

        // R5 writes dropped while busy
        setup(16'h0300, 16'd32, 1'b0);
        model_op(16'h0300, 16'd32, 1'b0);
        wr(16'hFF00, 8'd1);
        wr(16'hFF20, ~key0_b(0));
        wr(16'hFF06, 8'd1);
        rd(16'hFF01, d); check(d != 8'h00, "R5 read served while busy", d, 1);
        wr(16'hFF00, 8'd1);
        drive(2'd0, 16'h0000, 8'd0);
        repeat (100) @(negedge clk);
        rd(16'hFF20, d); check(d == key0_b(0), "R5 key write dropped", d, key0_b(0));
        rd(16'hFF06, d); check(d == 8'h00, "R5 select write dropped", d, 0);
        rd(16'hFF01, d); check(d == 8'h00, "R5 restart ignored", d, 0);
        compare_mem("R5/R9 busy pass result");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule